// File: doc/BRIEF.md
# Prescaled Primary Time Base

A 24-bit free-running time base that channels use as a shared reference for time. It advances by one on every terminal count of a prescaler. The prescaler is fed from one of two sources. With the system clock as source, the prescaler divides by an even ratio between 2 and 512. With an asynchronous external clock pin as source, it divides by any ratio between 1 and 256. Rising edges on the pin are synchronised and detected before they are counted.

Two agents see the count. The engine side can overwrite the count at any time, and its write also restarts the prescaler phase. The host side can only read. Anything the host writes is dropped without effect. Channels receive the count value, a one-cycle tick strobe that marks each advance, and a one-cycle overflow strobe when the count wraps. A new prescaler setting or a new source is not applied at once. It is taken over at the next terminal count, or at an engine write, so that no prescaler period is cut short.

Top module: `primary_timebase`

## Requirements
- R1: While reset is active, and in the first cycle after it, the count is 0 and both tickOut and ovfOut are low.
- R2: When the source select cfgSrcExt is 0, the count advances once every 2×(N+1) clock cycles, where N is the 8-bit field cfgSysDiv. The first advance comes 2×(N+1) cycles after the edge that loaded the phase.
- R3: When cfgSrcExt is 1, the count advances once for every M+1 rising edges of extClkIn, where M is the 8-bit field cfgExtDiv. The pin passes through a two-flop synchroniser and a rising-edge detector before it is counted.
- R4: engWrEn loads engWrData into the count at the next clock edge and restarts the prescaler phase at zero. A write that falls on a terminal count wins, and the count does not also advance.
- R5: hostWrEn and hostWrData never change the count or the prescaler phase.
- R6: The count wraps from 0xFFFFFF to 0. ovfOut is high for exactly the one cycle in which the wrapped value 0 is shown.
- R7: Changes to cfgSrcExt, cfgSysDiv or cfgExtDiv take effect only at the next terminal count or engine write. The period already in progress completes with the old setting.
- R8: engRdData and hostRdData both equal countOut in every cycle.
- R9: tickOut is a one-cycle strobe. It is high exactly in the cycles whose closing edge advances the count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClkIn | input | 1 | Asynchronous external clock pin |
| cfgSrcExt | input | 1 | Source select: 0 system clock, 1 external pin |
| cfgSysDiv | input | 8 | N; system-clock ratio 2×(N+1) |
| cfgExtDiv | input | 8 | M; external ratio M+1 |
| engWrEn | input | 1 | Engine write strobe |
| engWrData | input | 24 | Engine write value |
| engRdData | output | 24 | Engine read of the count |
| hostWrEn | input | 1 | Host write strobe (ignored) |
| hostWrData | input | 24 | Host write value (ignored) |
| hostRdData | output | 24 | Host read of the count |
| countOut | output | 24 | Count value to channels |
| tickOut | output | 1 | One-cycle strobe per advance |
| ovfOut | output | 1 | One-cycle strobe on wrap to zero |

## Verification
Some properties are checked on every cycle:
- an engine write loads its value;
- a tick adds exactly one;
- the count holds when there is neither a tick nor a write;
- a raised overflow strobe shows a zero count;
- the prescaler phase steps by one in system-clock mode and freezes between external edges;
- the active setting changes only at a terminal count or a write.

Other behaviour only the bench scenarios can show:
- the end-to-end ratios for random N and M;
- the write-beats-tick case;
- the deferred take-over of a new ratio partway through a period;
- the wrap to zero;
- the host writes that leave the count untouched.

// File: rtl/primary_timebase_pkg.sv
package primary_timebase_pkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic load;   // engine write: load new count
    logic inc;    // prescaler terminal count: advance
  } tbStrobe_t;
endpackage

// File: rtl/primary_timebase_ctrl.sv
module primary_timebase_ctrl
  import primary_timebase_pkg::*;
#(
  parameter int SYS_DIV_W   = 8,
  parameter int EXT_DIV_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extClkIn,
  input  logic                 cfgSrcExt,
  input  logic [SYS_DIV_W-1:0] cfgSysDiv,
  input  logic [EXT_DIV_W-1:0] cfgExtDiv,
  input  logic                 engWrEn,
  output tbStrobe_t            strobe
);
  localparam int PRE_W = (SYS_DIV_W + 1 > EXT_DIV_W) ? SYS_DIV_W + 1 : EXT_DIV_W;

  // Synchroniser chain for the external pin
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLvl;
  logic                   extEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= extClkIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extClkIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncChain[SYNC_STAGES-1];
  end

  assign extEdge = syncChain[SYNC_STAGES-1] & ~prevLvl;

  // Active (applied) configuration, taken over at terminal count or write
  logic                 activeSrc;
  logic [SYS_DIV_W-1:0] activeSysDiv;
  logic [EXT_DIV_W-1:0] activeExtDiv;
  logic [PRE_W-1:0]     preCnt;
  logic                 sysTerm;
  logic                 extTerm;
  logic                 term;
  logic                 preStep;

  assign sysTerm = (preCnt == PRE_W'({activeSysDiv, 1'b1}));
  assign extTerm = extEdge && (preCnt == PRE_W'(activeExtDiv));
  assign term    = activeSrc ? extTerm : sysTerm;
  assign preStep = activeSrc ? extEdge : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt       <= '0;
      activeSrc    <= 1'b0;
      activeSysDiv <= '0;
      activeExtDiv <= '0;
    end else if (engWrEn || term) begin
      preCnt       <= '0;
      activeSrc    <= cfgSrcExt;
      activeSysDiv <= cfgSysDiv;
      activeExtDiv <= cfgExtDiv;
    end else if (preStep) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign strobe.load = engWrEn;
  assign strobe.inc  = term && !engWrEn;

  // R2: system-clock phase steps by one each non-terminal cycle
  p_sys_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!activeSrc && !engWrEn && !term) |=> (preCnt == PRE_W'($past(preCnt) + 1'b1)));

  // R2: even ratio of at least two means no back-to-back ticks in system mode
  p_sys_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!activeSrc && strobe.inc && !cfgSrcExt) |=> !strobe.inc);

  // R3: phase frozen between synchronised external edges
  p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeSrc && !engWrEn && !extEdge) |=> $stable(preCnt));

  // R7: applied setting changes only at terminal count or engine write
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!engWrEn && !term) |=> $stable({activeSrc, activeSysDiv, activeExtDiv}));

  // R4: a write restarts the phase
  p_phase_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    engWrEn |=> (preCnt == '0));
endmodule

// File: rtl/primary_timebase_dp.sv
module primary_timebase_dp
  import primary_timebase_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (strobe.load) begin
      count <= wrData;
      ovf   <= 1'b0;
    end else if (strobe.inc) begin
      count <= count + 1'b1;
      ovf   <= (count == CNT_MAX);
    end else begin
      ovf   <= 1'b0;
    end
  end

  // R4: engine write lands in the count
  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(wrData)));

  // R9: each tick adds exactly one
  p_inc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.load) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R5: with no tick and no engine write the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.load) |=> $stable(count));

  // R6: overflow strobe shows the wrapped zero
  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (count == '0));

  // R6: overflow lasts one cycle
  p_ovf_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !ovf);
endmodule

// File: rtl/primary_timebase.sv
module primary_timebase
  import primary_timebase_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYS_DIV_W   = 8,
  parameter int EXT_DIV_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extClkIn,
  input  logic                 cfgSrcExt,
  input  logic [SYS_DIV_W-1:0] cfgSysDiv,
  input  logic [EXT_DIV_W-1:0] cfgExtDiv,
  input  logic                 engWrEn,
  input  logic [CNT_W-1:0]     engWrData,
  output logic [CNT_W-1:0]     engRdData,
  input  logic                 hostWrEn,
  input  logic [CNT_W-1:0]     hostWrData,
  output logic [CNT_W-1:0]     hostRdData,
  output logic [CNT_W-1:0]     countOut,
  output logic                 tickOut,
  output logic                 ovfOut
);
  tbStrobe_t strobe;
  logic      hostWrUnused;

  // Host side has read access only; its write lines reach nothing
  assign hostWrUnused = ^{hostWrEn, hostWrData};

  primary_timebase_ctrl #(
    .SYS_DIV_W  (SYS_DIV_W),
    .EXT_DIV_W  (EXT_DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .extClkIn (extClkIn),
    .cfgSrcExt(cfgSrcExt),
    .cfgSysDiv(cfgSysDiv),
    .cfgExtDiv(cfgExtDiv),
    .engWrEn  (engWrEn),
    .strobe   (strobe)
  );

  primary_timebase_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(engWrData),
    .count (countOut),
    .ovf   (ovfOut)
  );

  assign engRdData  = countOut;
  assign hostRdData = countOut;
  assign tickOut    = strobe.inc;
endmodule

// File: tb/primary_timebase_tb_top.sv
module primary_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClkIn = 1'b0;
  logic        cfgSrcExt = 1'b0;
  logic [7:0]  cfgSysDiv = '0;
  logic [7:0]  cfgExtDiv = '0;
  logic        engWrEn = 1'b0;
  logic [23:0] engWrData = '0;
  logic [23:0] engRdData;
  logic        hostWrEn = 1'b0;
  logic [23:0] hostWrData = '0;
  logic [23:0] hostRdData;
  logic [23:0] countOut;
  logic        tickOut;
  logic        ovfOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  primary_timebase dut_i (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn), .cfgSrcExt(cfgSrcExt),
    .cfgSysDiv(cfgSysDiv), .cfgExtDiv(cfgExtDiv), .engWrEn(engWrEn),
    .engWrData(engWrData), .engRdData(engRdData), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .countOut(countOut),
    .tickOut(tickOut), .ovfOut(ovfOut)
  );

  function automatic logic [23:0] expSys(logic [23:0] base, int cycles, int n);
    return base + 24'(cycles / (2 * (n + 1)));
  endfunction

  function automatic logic [23:0] expExt(logic [23:0] base, int edges, int m);
    return base + 24'(edges / (m + 1));
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the loading edge
  task automatic engWrite(logic [23:0] val);
    engWrEn = 1'b1;
    engWrData = val;
    @(negedge clk);
    engWrEn = 1'b0;
  endtask

  task automatic extPulses(int p);
    for (int i = 0; i < p; i++) begin
      extClkIn = 1'b1;
      repeat (3) @(negedge clk);
      extClkIn = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 count in reset", countOut, 24'h0);
    check("R1 tick in reset", {23'h0, tickOut}, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count after reset", countOut, 24'h0);
    check("R1 ovf after reset", {23'h0, ovfOut}, 24'h0);

    // R2 random system-clock ratios
    for (int t = 0; t < 8; t++) begin
      int n = $urandom % 8;
      int k = ($urandom % 60) + 1;
      logic [23:0] d = 24'($urandom);
      cfgSrcExt = 1'b0;
      cfgSysDiv = 8'(n);
      engWrite(d);
      repeat (k) @(negedge clk);
      check("R2 system ratio", countOut, expSys(d, k, n));
    end

    // R9 + R8: tick count over a window with ratio 4
    begin
      int ticks = 0;
      cfgSysDiv = 8'd1;
      engWrite(24'h000100);
      for (int i = 0; i < 40; i++) begin
        if (tickOut) ticks++;
        if (engRdData !== countOut || hostRdData !== countOut)
          check("R8 read ports", hostRdData, countOut);
        @(negedge clk);
      end
      check("R9 tick count", 24'(ticks), 24'd10);
      check("R8 engine read", engRdData, countOut);
      check("R8 host read", hostRdData, countOut);
    end

    // R4 write on a terminal count wins, phase restarts
    cfgSysDiv = 8'd1;
    engWrite(24'h000050);
    repeat (3) @(negedge clk);
    engWrite(24'h000A00);
    repeat (3) @(negedge clk);
    check("R4 write beats tick", countOut, 24'h000A00);
    @(negedge clk);
    check("R4 phase restart", countOut, 24'h000A01);

    // R6 wrap
    cfgSysDiv = 8'd0;
    engWrite(24'hFFFFFE);
    repeat (3) @(negedge clk);
    check("R6 before wrap", countOut, 24'hFFFFFF);
    check("R6 no early ovf", {23'h0, ovfOut}, 24'h0);
    @(negedge clk);
    check("R6 wrapped", countOut, 24'h0);
    check("R6 ovf pulse", {23'h0, ovfOut}, 24'h1);
    @(negedge clk);
    check("R6 ovf one cycle", {23'h0, ovfOut}, 24'h0);

    // R7 deferred ratio change
    cfgSysDiv = 8'd3;
    engWrite(24'h000200);
    repeat (3) @(negedge clk);
    cfgSysDiv = 8'd0;
    repeat (4) @(negedge clk);
    check("R7 old period holds", countOut, 24'h000200);
    @(negedge clk);
    check("R7 old period ends", countOut, 24'h000201);
    repeat (4) @(negedge clk);
    check("R7 new ratio", countOut, 24'h000203);

    // R5 host writes ignored
    cfgSysDiv = 8'd255;
    engWrite(24'h123456);
    for (int i = 0; i < 10; i++) begin
      hostWrEn = 1'b1;
      hostWrData = 24'($urandom);
      @(negedge clk);
    end
    hostWrEn = 1'b0;
    check("R5 host write ignored", countOut, 24'h123456);
    check("R5 host read", hostRdData, 24'h123456);

    // R3 external source, random ratios and edge counts
    for (int t = 0; t < 6; t++) begin
      int m = $urandom % 5;
      int p = $urandom % 16;
      logic [23:0] d = 24'($urandom);
      extClkIn = 1'b0;
      repeat (4) @(negedge clk);
      cfgSrcExt = 1'b1;
      cfgExtDiv = 8'(m);
      engWrite(d);
      extPulses(p);
      repeat (6) @(negedge clk);
      check("R3 external ratio", countOut, expExt(d, p, m));
    end

    // R3 ratio 1: every edge counts
    cfgExtDiv = 8'd0;
    engWrite(24'h000010);
    extPulses(7);
    repeat (6) @(negedge clk);
    check("R3 divide by one", countOut, 24'h000017);

    finishRun();
  end
endmodule